// File: doc/BRIEF.md
# Paging Translation Cache with Dirty Tracking

This block is a small, fully associative cache of page translations for a 32-bit linear address space with 4 KB pages. Each lookup presents a linear address, an access kind (instruction fetch, data read or data write) and a flag that marks a request made at privilege level 3. When a valid entry covers the page and allows the access, the physical address comes back one cycle later. A failed permission check on a cached entry produces a page-fault error code at once, with no page walk. The cache keeps a dirty flag in every entry. A write that finds a clean entry is treated as a miss, so the external walker gets the chance to set the dirty bit in memory.

On a miss the block raises a walk request and holds the linear address, the kind and the privilege flag steady. It takes no new lookups until the walker acknowledges. A successful walk installs an entry and answers the lookup. A failed walk answers with a fault code built from the walker's present indication.

Translations are dropped wholesale in these cases:
- reset;
- a page-directory base write;
- a change of the A20 mask;
- a control-register write that toggles paging enable or write protect.

A single-page invalidate drops one entry, after its own privilege and operand-form checks.

Top module: `pg_xlat_cache`

## Requirements
- R1: A lookup accepted while `req_ready` is high and that hits with permission gives `resp_valid` high in the next cycle with `resp_fault` low and `resp_phys` = {cached frame, `req_lin[11:0]`}. The page number is `req_lin[31:12]`.
- R2: A lookup with no valid entry for its page raises `walk_req` in the next cycle. `walk_lin`, `walk_kind` and `walk_user` carry the request until the cycle in which `walk_ack` is high. `req_ready` is low while `walk_req` is high. The result appears on `resp_*` in the cycle after the acknowledge.
- R3: A write (`req_kind` = 2'b10) that finds a valid entry without its dirty flag is a miss and requests a walk. Once the fill is installed, a later write to that page hits.
- R4: A fetch (`req_kind` = 2'b00) is checked against the same permission bit as a read (`req_kind` = 2'b01). The code 2'b11 is also handled as a read.
- R5: Each entry holds four permission bits, as `walk_perm[0]` supervisor read, [1] supervisor write, [2] user read and [3] user write. A hit whose required bit is clear gives `resp_fault` high in the next cycle and raises no walk.
- R6: The fault code `resp_err` has bit 0 = page present (always 1 for a permission fault on a hit), bit 1 = write access, and bit 2 = `req_user` (privilege level 3).
- R7: When the walker acknowledges with `walk_ok` low, the response is a fault with `resp_err` = {`walk_user`, write, `walk_present`}, and no entry is installed.
- R8: A fill for a page that is not cached goes into the slot named by a round-robin pointer. The pointer advances by one and wraps at the entry count. Any page already in that slot is evicted.
- R9: A fill for a page that is already cached, as after a dirty re-walk, overwrites that entry in place. The round-robin pointer does not advance.
- R10: All entries are invalid after reset, after `cr3_wr`, and after `a20_chg`. The next lookup of any page then walks.
- R11: A `cr0_wr` flushes every entry only when `cr0_old` and `cr0_new` differ in bit 31 or bit 16. A change in other bits leaves the cached entries in place.
- R12: An accepted single-page invalidate drops only the entry for `inv_lin[31:12]`. Other pages still hit.
- R13: An invalidate with `inv_prot` high and `inv_cpl` nonzero pulses `inv_gp` in the next cycle. Otherwise, an invalidate with `inv_reg_form` high pulses `inv_ud`. In both cases no entry is dropped, and the general-protection check takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request |
| req_ready | output | 1 | High when a lookup can be accepted |
| req_lin | input | 32 | Linear address to translate |
| req_kind | input | 2 | 00 fetch, 01 read, 10 write, 11 read |
| req_user | input | 1 | Request made at privilege level 3 |
| resp_valid | output | 1 | One-cycle result strobe |
| resp_fault | output | 1 | Result is a page fault |
| resp_phys | output | 32 | Physical address on success, zero on a fault |
| resp_err | output | 3 | Page-fault error code |
| walk_req | output | 1 | Walk request, held until acknowledged |
| walk_lin | output | 32 | Linear address for the walker |
| walk_kind | output | 2 | Access kind for the walker |
| walk_user | output | 1 | Privilege-3 flag for the walker |
| walk_ack | input | 1 | Walker completion, one cycle |
| walk_ok | input | 1 | Walk succeeded |
| walk_present | input | 1 | Page was present (for a failed walk) |
| walk_frame | input | 20 | Physical frame number |
| walk_perm | input | 4 | Permission bits as in R5 |
| walk_dirty | input | 1 | Page marked dirty by the walk |
| cr0_wr | input | 1 | Control register 0 write strobe |
| cr0_old | input | 32 | Value before the write |
| cr0_new | input | 32 | Value after the write |
| cr3_wr | input | 1 | Page-directory base write strobe |
| a20_chg | input | 1 | A20 mask changed |
| inv_valid | input | 1 | Single-page invalidate |
| inv_lin | input | 32 | Address whose page is invalidated |
| inv_prot | input | 1 | Processor in protected mode |
| inv_cpl | input | 2 | Current privilege level |
| inv_reg_form | input | 1 | Operand given in register form |
| inv_gp | output | 1 | General-protection fault pulse |
| inv_ud | output | 1 | Undefined-opcode fault pulse |

## Verification
The hardest states to reach are those that depend on where the round-robin pointer sits. One is the eviction of the oldest page. The other is an in-place dirty refill that must leave the pointer alone. Neither is visible at the ports. The stimulus therefore fills exactly as many distinct pages as there are slots after a flush, forces a dirty re-walk of the first page, and then adds one more page. Whether the second page still hits shows whether the pointer moved. A behavioural model in the bench tracks every entry and the pointer on each clock. Permission faults on hits are reached by installing pages through supervisor accesses and then touching them from user level.

// File: rtl/xc_pkg.sv
package xc_pkg;
  localparam int XC_ADDR_W = 32;
  localparam int XC_OFF_W  = 12;
  localparam int XC_VPN_W  = XC_ADDR_W - XC_OFF_W;
  localparam int XC_PERM_W = 4;
  localparam logic [XC_ADDR_W-1:0] XC_CR0_FLUSH_MASK = 32'h8001_0000;

  typedef enum logic [1:0] {
    KIND_FETCH = 2'b00,
    KIND_READ  = 2'b01,
    KIND_WRITE = 2'b10,
    KIND_RSVD  = 2'b11
  } kind_e;

  typedef enum logic {ST_IDLE, ST_WALK} xc_state_e;

  typedef struct packed {
    logic                 valid;
    logic                 dirty;
    logic [XC_PERM_W-1:0] perm;
    logic [XC_VPN_W-1:0]  vpn;
    logic [XC_VPN_W-1:0]  frame;
  } xc_entry_t;

  function automatic logic is_write(input logic [1:0] kind);
    return kind == KIND_WRITE;
  endfunction

  // perm index: bit1 = user, bit0 = write (fetch maps to read)
  function automatic logic [1:0] perm_sel(input logic user, input logic wr);
    return {user, wr};
  endfunction

  function automatic logic [2:0] page_err(input logic present, input logic wr,
                                          input logic user);
    return {user, wr, present};
  endfunction

  function automatic logic [XC_ADDR_W-1:0] join_phys(
      input logic [XC_VPN_W-1:0] frame, input logic [XC_OFF_W-1:0] off);
    return {frame, off};
  endfunction

  function automatic logic cr0_flush_needed(input logic [XC_ADDR_W-1:0] old_v,
                                            input logic [XC_ADDR_W-1:0] new_v);
    return ((old_v ^ new_v) & XC_CR0_FLUSH_MASK) != '0;
  endfunction
endpackage

// File: rtl/xc_victim.sv
module xc_victim #(
  parameter int ENTRIES = 32,
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [IW-1:0] ptr
);
  localparam logic [IW-1:0] LAST = IW'(ENTRIES - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ptr <= '0;
    else if (adv) ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
  end
endmodule

// File: rtl/xc_inval.sv
module xc_inval (
  input  logic       inv_valid,
  input  logic       inv_prot,
  input  logic [1:0] inv_cpl,
  input  logic       inv_reg_form,
  output logic       gp_fault,
  output logic       ud_fault,
  output logic       drop
);
  always_comb begin
    gp_fault = 1'b0;
    ud_fault = 1'b0;
    drop     = 1'b0;
    if (inv_valid) begin
      if (inv_prot && inv_cpl != 2'd0) gp_fault = 1'b1;
      else if (inv_reg_form)           ud_fault = 1'b1;
      else                             drop     = 1'b1;
    end
  end
endmodule

// File: rtl/xc_store.sv
module xc_store
  import xc_pkg::*;
#(
  parameter int ENTRIES = 32,
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [XC_VPN_W-1:0] look_vpn,
  output logic                look_hit,
  output logic [IW-1:0]       look_idx,
  output xc_entry_t           look_ent,
  input  logic                wr_en,
  input  logic [IW-1:0]       wr_idx,
  input  xc_entry_t           wr_ent,
  input  logic                inv_en,
  input  logic [XC_VPN_W-1:0] inv_vpn,
  input  logic                flush_all,
  output logic [ENTRIES-1:0]  valid_vec
);
  xc_entry_t           ents [ENTRIES];
  logic [ENTRIES-1:0]  match;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    logic      wr_here;
    xc_entry_t next_ent;
    assign wr_here = wr_en && (wr_idx == IW'(i));
    assign next_ent = wr_here ? wr_ent : ents[i];
    assign match[i] = ents[i].valid && (ents[i].vpn == look_vpn);
    assign valid_vec[i] = ents[i].valid;

    // flush beats fill; invalidate applies to the post-fill contents
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ents[i] <= '0;
      end else if (flush_all) begin
        ents[i].valid <= 1'b0;
      end else begin
        ents[i] <= next_ent;
        if (inv_en && next_ent.vpn == inv_vpn) ents[i].valid <= 1'b0;
      end
    end
  end

  always_comb begin
    look_idx = '0;
    look_ent = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) begin
        look_idx = IW'(i);
        look_ent = ents[i];
      end
    end
  end

  assign look_hit = |match;
endmodule

// File: rtl/pg_xlat_cache.sv
module pg_xlat_cache
  import xc_pkg::*;
#(
  parameter int ENTRIES = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_lin,
  input  logic [1:0]  req_kind,
  input  logic        req_user,
  output logic        resp_valid,
  output logic        resp_fault,
  output logic [31:0] resp_phys,
  output logic [2:0]  resp_err,
  output logic        walk_req,
  output logic [31:0] walk_lin,
  output logic [1:0]  walk_kind,
  output logic        walk_user,
  input  logic        walk_ack,
  input  logic        walk_ok,
  input  logic        walk_present,
  input  logic [19:0] walk_frame,
  input  logic [3:0]  walk_perm,
  input  logic        walk_dirty,
  input  logic        cr0_wr,
  input  logic [31:0] cr0_old,
  input  logic [31:0] cr0_new,
  input  logic        cr3_wr,
  input  logic        a20_chg,
  input  logic        inv_valid,
  input  logic [31:0] inv_lin,
  input  logic        inv_prot,
  input  logic [1:0]  inv_cpl,
  input  logic        inv_reg_form,
  output logic        inv_gp,
  output logic        inv_ud
);
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  xc_state_e           state_q;
  logic [31:0]         wlin_q;
  logic [1:0]          wkind_q;
  logic                wuser_q;

  logic [XC_VPN_W-1:0] look_vpn;
  logic                look_hit;
  logic [IW-1:0]       look_idx;
  xc_entry_t           look_ent;
  logic [IW-1:0]       victim_ptr;
  logic [ENTRIES-1:0]  valid_vec;

  // named events
  logic      lookup_fire, lookup_miss, lookup_hit_ok, lookup_perm_fault;
  logic      lk_write, lk_perm_ok;
  logic      fill_fire, fill_ok, alloc_new;
  logic      flush_all, inv_drop, gp_now, ud_now;
  logic [IW-1:0] wr_idx;
  xc_entry_t wr_ent;

  assign req_ready   = (state_q == ST_IDLE);
  assign lookup_fire = req_valid && req_ready;
  assign look_vpn    = (state_q == ST_WALK) ? wlin_q[31:12] : req_lin[31:12];
  assign lk_write    = is_write(req_kind);

  // R3: a write to a clean entry is a miss
  assign lookup_miss = lookup_fire && (!look_hit || (lk_write && !look_ent.dirty));
  assign lk_perm_ok  = look_ent.perm[perm_sel(req_user, lk_write)];
  assign lookup_hit_ok     = lookup_fire && !lookup_miss && lk_perm_ok;
  assign lookup_perm_fault = lookup_fire && !lookup_miss && !lk_perm_ok;

  assign fill_fire = (state_q == ST_WALK) && walk_ack;
  assign fill_ok   = fill_fire && walk_ok;
  // R9: page already cached -> in place; R8: otherwise round-robin slot
  assign alloc_new = fill_ok && !look_hit;
  assign wr_idx    = look_hit ? look_idx : victim_ptr;

  always_comb begin
    wr_ent       = '0;
    wr_ent.valid = 1'b1;
    wr_ent.dirty = walk_dirty;
    wr_ent.perm  = walk_perm;
    wr_ent.vpn   = wlin_q[31:12];
    wr_ent.frame = walk_frame;
  end

  // R10, R11
  assign flush_all = cr3_wr || a20_chg || (cr0_wr && cr0_flush_needed(cr0_old, cr0_new));

  xc_store #(.ENTRIES(ENTRIES)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .look_vpn  (look_vpn),
    .look_hit  (look_hit),
    .look_idx  (look_idx),
    .look_ent  (look_ent),
    .wr_en     (fill_ok),
    .wr_idx    (wr_idx),
    .wr_ent    (wr_ent),
    .inv_en    (inv_drop),
    .inv_vpn   (inv_lin[31:12]),
    .flush_all (flush_all),
    .valid_vec (valid_vec)
  );

  xc_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (alloc_new && !flush_all),
    .ptr   (victim_ptr)
  );

  xc_inval u_inval (
    .inv_valid    (inv_valid),
    .inv_prot     (inv_prot),
    .inv_cpl      (inv_cpl),
    .inv_reg_form (inv_reg_form),
    .gp_fault     (gp_now),
    .ud_fault     (ud_now),
    .drop         (inv_drop)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      wlin_q     <= '0;
      wkind_q    <= KIND_READ;
      wuser_q    <= 1'b0;
      resp_valid <= 1'b0;
      resp_fault <= 1'b0;
      resp_phys  <= '0;
      resp_err   <= '0;
      inv_gp     <= 1'b0;
      inv_ud     <= 1'b0;
    end else begin
      resp_valid <= 1'b0;
      inv_gp     <= gp_now;
      inv_ud     <= ud_now;
      if (lookup_hit_ok) begin
        resp_valid <= 1'b1;
        resp_fault <= 1'b0;
        resp_phys  <= join_phys(look_ent.frame, req_lin[11:0]);
        resp_err   <= '0;
      end else if (lookup_perm_fault) begin
        resp_valid <= 1'b1;
        resp_fault <= 1'b1;
        resp_phys  <= '0;
        resp_err   <= page_err(1'b1, lk_write, req_user);
      end else if (lookup_miss) begin
        state_q <= ST_WALK;
        wlin_q  <= req_lin;
        wkind_q <= req_kind;
        wuser_q <= req_user;
      end
      if (fill_fire) begin
        state_q    <= ST_IDLE;
        resp_valid <= 1'b1;
        if (walk_ok) begin
          resp_fault <= 1'b0;
          resp_phys  <= join_phys(walk_frame, wlin_q[11:0]);
          resp_err   <= '0;
        end else begin
          resp_fault <= 1'b1;
          resp_phys  <= '0;
          resp_err   <= page_err(walk_present, is_write(wkind_q), wuser_q);
        end
      end
    end
  end

  assign walk_req  = (state_q == ST_WALK);
  assign walk_lin  = wlin_q;
  assign walk_kind = wkind_q;
  assign walk_user = wuser_q;

  logic unused_bits;
  assign unused_bits = ^{inv_lin[11:0], look_ent.valid, look_ent.vpn, valid_vec};
endmodule

// File: rtl/xc_checker.sv
module xc_checker #(
  parameter int ENTRIES = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_ready,
  input logic [11:0]        req_off,
  input logic [1:0]         req_kind,
  input logic               resp_valid,
  input logic               resp_fault,
  input logic [31:0]        resp_phys,
  input logic [2:0]         resp_err,
  input logic               walk_req,
  input logic               walk_ack,
  input logic               walk_ok,
  input logic               walk_present,
  input logic [31:0]        walk_lin,
  input logic               lookup_fire,
  input logic               lookup_hit_ok,
  input logic               lookup_perm_fault,
  input logic               lookup_miss,
  input logic               fill_fire,
  input logic               flush_all,
  input logic [ENTRIES-1:0] valid_vec,
  input logic               inv_gp,
  input logic               inv_ud
);
  assert_hit_phys_R1: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_fire && lookup_hit_ok |=> resp_valid && !resp_fault && resp_phys[11:0] == $past(req_off));

  assert_walk_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req && !walk_ack |=> walk_req && $stable(walk_lin));

  assert_busy_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req |-> !req_ready);

  assert_miss_walks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_fire && lookup_miss |=> walk_req && !resp_valid);

  assert_perm_nowalk_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_fire && lookup_perm_fault |=> resp_valid && resp_fault && !walk_req);

  assert_err_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_fire && lookup_perm_fault |=> resp_err[0] && resp_err[1] == $past(req_kind == 2'b10));

  assert_walk_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fill_fire && !walk_ok |=> resp_valid && resp_fault && resp_err[0] == $past(walk_present));

  assert_flush_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> valid_vec == '0);

  assert_inv_excl_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({inv_gp, inv_ud}));
endmodule

bind pg_xlat_cache xc_checker #(.ENTRIES(ENTRIES)) u_chk (
  .clk               (clk),
  .rst_n             (rst_n),
  .req_ready         (req_ready),
  .req_off           (req_lin[11:0]),
  .req_kind          (req_kind),
  .resp_valid        (resp_valid),
  .resp_fault        (resp_fault),
  .resp_phys         (resp_phys),
  .resp_err          (resp_err),
  .walk_req          (walk_req),
  .walk_ack          (walk_ack),
  .walk_ok           (walk_ok),
  .walk_present      (walk_present),
  .walk_lin          (walk_lin),
  .lookup_fire       (lookup_fire),
  .lookup_hit_ok     (lookup_hit_ok),
  .lookup_perm_fault (lookup_perm_fault),
  .lookup_miss       (lookup_miss),
  .fill_fire         (fill_fire),
  .flush_all         (flush_all),
  .valid_vec         (valid_vec),
  .inv_gp            (inv_gp),
  .inv_ud            (inv_ud)
);

// File: tb/sim_pg_xlat_cache.sv
`timescale 1ns/1ps
module sim_pg_xlat_cache;
  localparam int NE = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_lin = '0;
  logic [1:0]  req_kind = 2'b01;
  logic        req_user = 1'b0;
  logic        resp_valid, resp_fault;
  logic [31:0] resp_phys;
  logic [2:0]  resp_err;
  logic        walk_req;
  logic [31:0] walk_lin;
  logic [1:0]  walk_kind;
  logic        walk_user;
  logic        walk_ack = 1'b0, walk_ok = 1'b0, walk_present = 1'b0;
  logic [19:0] walk_frame = '0;
  logic [3:0]  walk_perm = '0;
  logic        walk_dirty = 1'b0;
  logic        cr0_wr = 1'b0;
  logic [31:0] cr0_old = '0, cr0_new = '0;
  logic        cr3_wr = 1'b0, a20_chg = 1'b0;
  logic        inv_valid = 1'b0;
  logic [31:0] inv_lin = '0;
  logic        inv_prot = 1'b0;
  logic [1:0]  inv_cpl = '0;
  logic        inv_reg_form = 1'b0;
  logic        inv_gp, inv_ud;

  always #5 clk = ~clk;

  pg_xlat_cache #(.ENTRIES(NE)) u0 (.*);

  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;
  string tag = "R10";

  task automatic chk(input string rq, input string what, input logic [31:0] got,
                     input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", rq, what, got, exp);
    end
  endtask

  // ---------------- behavioural walker ----------------
  logic       w_ok = 1'b1, w_present = 1'b1, w_dirty = 1'b0;
  logic [3:0] w_perm = 4'b1111;
  int         wcnt = 0;

  function automatic logic [19:0] frame_of(input logic [19:0] vpn);
    return vpn ^ 20'hA5A5A;
  endfunction

  always @(negedge clk) begin
    if (walk_req && !walk_ack) begin
      wcnt++;
      if (wcnt >= 2) begin
        walk_ack     = 1'b1;
        walk_ok      = w_ok;
        walk_present = w_present;
        walk_frame   = frame_of(walk_lin[31:12]);
        walk_perm    = w_perm;
        walk_dirty   = (walk_kind == 2'b10) ? 1'b1 : w_dirty;
      end
    end else begin
      walk_ack = 1'b0;
      wcnt = 0;
    end
  end

  // ---------------- reference model ----------------
  bit          m_v [NE];
  bit          m_d [NE];
  logic [3:0]  m_p [NE];
  logic [19:0] m_vpn [NE];
  logic [19:0] m_fr [NE];
  int          m_rr = 0;
  bit          m_walk = 0;
  logic [31:0] m_wlin;
  logic [1:0]  m_wkind;
  bit          m_wuser;
  bit          e_rv, e_rf, e_gp, e_ud;
  logic [31:0] e_phys;
  logic [2:0]  e_err;

  function automatic int m_find(input logic [19:0] vpn);
    for (int i = 0; i < NE; i++) if (m_v[i] && m_vpn[i] == vpn) return i;
    return -1;
  endfunction

  always @(posedge clk) begin
    e_rv = 0; e_rf = 0; e_gp = 0; e_ud = 0; e_phys = '0; e_err = '0;
    if (!rst_n) begin
      for (int i = 0; i < NE; i++) m_v[i] = 0;
      m_rr = 0; m_walk = 0;
    end else begin
      if (!m_walk && req_valid) begin
        int  k;
        bit  wr, us;
        wr = (req_kind == 2'b10);
        us = req_user;
        k  = m_find(req_lin[31:12]);
        if (k < 0 || (wr && !m_d[k])) begin
          m_walk = 1; m_wlin = req_lin; m_wkind = req_kind; m_wuser = us;
        end else if (m_p[k][(us ? 2 : 0) + (wr ? 1 : 0)]) begin
          e_rv = 1; e_phys = {m_fr[k], req_lin[11:0]};
        end else begin
          e_rv = 1; e_rf = 1; e_err = {us, wr, 1'b1};
        end
      end else if (m_walk && walk_ack) begin
        m_walk = 0;
        e_rv = 1;
        if (walk_ok) begin
          int k;
          k = m_find(m_wlin[31:12]);
          if (k < 0) begin
            k = m_rr;
            m_rr = (m_rr + 1) % NE;
          end
          m_v[k] = 1; m_d[k] = walk_dirty; m_p[k] = walk_perm;
          m_vpn[k] = m_wlin[31:12]; m_fr[k] = walk_frame;
          e_phys = {walk_frame, m_wlin[11:0]};
        end else begin
          e_rf = 1;
          e_err = {m_wuser, m_wkind == 2'b10, walk_present};
        end
      end
      if (inv_valid) begin
        if (inv_prot && inv_cpl != 0) e_gp = 1;
        else if (inv_reg_form) e_ud = 1;
        else for (int i = 0; i < NE; i++)
          if (m_vpn[i] == inv_lin[31:12]) m_v[i] = 0;
      end
      if (cr3_wr || a20_chg ||
          (cr0_wr && ((cr0_old ^ cr0_new) & 32'h8001_0000) != 0)) begin
        for (int i = 0; i < NE; i++) m_v[i] = 0;
      end
    end
    #3;
    if (!done) begin
      chk(tag, "cycle req_ready", {31'd0, req_ready}, {31'd0, !m_walk});
      chk(tag, "cycle walk_req", {31'd0, walk_req}, {31'd0, m_walk});
      if (m_walk) chk(tag, "cycle walk_lin", walk_lin, m_wlin);
      chk(tag, "cycle resp_valid", {31'd0, resp_valid}, {31'd0, e_rv});
      if (e_rv) begin
        chk(tag, "cycle resp_fault", {31'd0, resp_fault}, {31'd0, e_rf});
        chk(tag, "cycle resp_err", {29'd0, resp_err}, {29'd0, e_err});
        chk(tag, "cycle resp_phys", resp_phys, e_phys);
      end
      chk(tag, "cycle inv_gp", {31'd0, inv_gp}, {31'd0, e_gp});
      chk(tag, "cycle inv_ud", {31'd0, inv_ud}, {31'd0, e_ud});
    end
  end

  // ---------------- stimulus tasks ----------------
  logic [31:0] r_phys;
  logic        r_fault, r_walked;
  logic [2:0]  r_err;

  task automatic lookup(input logic [31:0] lin, input logic [1:0] kind, input logic user);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_lin = lin; req_kind = kind; req_user = user;
    @(negedge clk);
    req_valid = 1'b0;
    r_walked = 1'b0;
    while (!resp_valid) begin
      if (walk_req) r_walked = 1'b1;
      @(negedge clk);
    end
    r_phys = resp_phys; r_fault = resp_fault; r_err = resp_err;
  endtask

  function automatic logic [31:0] xp(input logic [31:0] lin);
    return {frame_of(lin[31:12]), lin[11:0]};
  endfunction

  task automatic pulse_cr3();
    @(negedge clk); cr3_wr = 1'b1; @(negedge clk); cr3_wr = 1'b0;
  endtask

  task automatic pulse_a20();
    @(negedge clk); a20_chg = 1'b1; @(negedge clk); a20_chg = 1'b0;
  endtask

  task automatic pulse_cr0(input logic [31:0] o, input logic [31:0] n);
    @(negedge clk); cr0_wr = 1'b1; cr0_old = o; cr0_new = n;
    @(negedge clk); cr0_wr = 1'b0;
  endtask

  task automatic invalidate(input logic [31:0] lin, input logic prot, input logic [1:0] cpl,
                            input logic regf, output logic gp, output logic ud);
    @(negedge clk);
    inv_valid = 1'b1; inv_lin = lin; inv_prot = prot; inv_cpl = cpl; inv_reg_form = regf;
    @(negedge clk);
    inv_valid = 1'b0;
    gp = inv_gp; ud = inv_ud;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog expired actual hung expected done");
    finish_run();
  end

  initial begin
    logic gp, ud;
    repeat (3) @(negedge clk);
    tag = "R10";
    chk("R10", "reset req_ready", {31'd0, req_ready}, 32'd1);
    chk("R10", "reset resp_valid", {31'd0, resp_valid}, 32'd0);
    chk("R10", "reset walk_req", {31'd0, walk_req}, 32'd0);
    rst_n = 1'b1;

    tag = "R2";
    lookup(32'h0001_0123, 2'b01, 1'b1);
    chk("R2", "first read walks", {31'd0, r_walked}, 32'd1);
    chk("R2", "fill phys", r_phys, xp(32'h0001_0123));
    tag = "R1";
    lookup(32'h0001_0ABC, 2'b01, 1'b1);
    chk("R1", "hit no walk", {31'd0, r_walked}, 32'd0);
    chk("R1", "hit phys", r_phys, xp(32'h0001_0ABC));
    tag = "R4";
    lookup(32'h0001_0004, 2'b00, 1'b1);
    chk("R4", "fetch hit no walk", {31'd0, r_walked}, 32'd0);
    chk("R4", "fetch phys", r_phys, xp(32'h0001_0004));

    tag = "R3";
    lookup(32'h0001_0010, 2'b10, 1'b1);
    chk("R3", "clean write rewalks", {31'd0, r_walked}, 32'd1);
    lookup(32'h0001_0020, 2'b10, 1'b1);
    chk("R3", "dirty write hits", {31'd0, r_walked}, 32'd0);
    chk("R3", "dirty write phys", r_phys, xp(32'h0001_0020));

    tag = "R5";
    w_perm = 4'b0011;
    lookup(32'h0002_0000, 2'b01, 1'b0);
    lookup(32'h0002_0044, 2'b01, 1'b1);
    chk("R5", "user read fault", {31'd0, r_fault}, 32'd1);
    chk("R5", "user read no walk", {31'd0, r_walked}, 32'd0);
    chk("R6", "err user read", {29'd0, r_err}, 32'd5);
    lookup(32'h0002_0048, 2'b00, 1'b1);
    chk("R4", "user fetch faults like read", {29'd0, r_err}, 32'd5);
    w_perm = 4'b0111;
    lookup(32'h0002_1000, 2'b10, 1'b0);
    lookup(32'h0002_1008, 2'b10, 1'b1);
    chk("R5", "user write fault no walk", {31'd0, r_walked}, 32'd0);
    chk("R6", "err user write", {29'd0, r_err}, 32'd7);
    lookup(32'h0002_100C, 2'b10, 1'b0);
    chk("R5", "super write ok", {31'd0, r_fault}, 32'd0);
    w_perm = 4'b1111;

    tag = "R7";
    w_ok = 1'b0; w_present = 1'b0;
    lookup(32'h0003_0000, 2'b01, 1'b0);
    chk("R7", "walk fault", {31'd0, r_fault}, 32'd1);
    chk("R7", "err not present", {29'd0, r_err}, 32'd0);
    w_present = 1'b1;
    lookup(32'h0003_1000, 2'b10, 1'b1);
    chk("R7", "err present write user", {29'd0, r_err}, 32'd7);
    w_ok = 1'b1;
    lookup(32'h0003_0000, 2'b01, 1'b0);
    chk("R7", "failed walk not installed", {31'd0, r_walked}, 32'd1);

    tag = "R10";
    lookup(32'h0004_0000, 2'b01, 1'b0);
    lookup(32'h0004_0000, 2'b01, 1'b0);
    chk("R10", "cached before cr3", {31'd0, r_walked}, 32'd0);
    pulse_cr3();
    lookup(32'h0004_0000, 2'b01, 1'b0);
    chk("R10", "cr3 flush", {31'd0, r_walked}, 32'd1);
    pulse_a20();
    lookup(32'h0004_0000, 2'b01, 1'b0);
    chk("R10", "a20 flush", {31'd0, r_walked}, 32'd1);
    tag = "R11";
    pulse_cr0(32'h8000_0001, 32'h8000_0021);
    lookup(32'h0004_0000, 2'b01, 1'b0);
    chk("R11", "cr0 other bit keeps", {31'd0, r_walked}, 32'd0);
    pulse_cr0(32'h8000_0001, 32'h8001_0001);
    lookup(32'h0004_0000, 2'b01, 1'b0);
    chk("R11", "cr0 bit16 flush", {31'd0, r_walked}, 32'd1);
    pulse_cr0(32'h8001_0001, 32'h0001_0001);
    lookup(32'h0004_0000, 2'b01, 1'b0);
    chk("R11", "cr0 bit31 flush", {31'd0, r_walked}, 32'd1);

    tag = "R8";
    pulse_cr3();
    for (int i = 0; i < NE; i++) lookup({12'h005, 8'(i), 12'h0}, 2'b01, 1'b0);
    for (int i = 0; i < NE; i++) begin
      lookup({12'h005, 8'(i), 12'h0}, 2'b01, 1'b0);
      chk("R8", "all slots hold", {31'd0, r_walked}, 32'd0);
    end
    lookup({12'h005, 8'(NE), 12'h0}, 2'b01, 1'b0);
    lookup({12'h005, 8'd1, 12'h0}, 2'b01, 1'b0);
    chk("R8", "second page kept", {31'd0, r_walked}, 32'd0);
    lookup({12'h005, 8'd0, 12'h0}, 2'b01, 1'b0);
    chk("R8", "oldest evicted", {31'd0, r_walked}, 32'd1);

    tag = "R9";
    pulse_cr3();
    for (int i = 0; i < NE; i++) lookup({12'h006, 8'(i), 12'h0}, 2'b01, 1'b0);
    lookup({12'h006, 8'd0, 12'h0}, 2'b10, 1'b0);
    chk("R9", "dirty rewalk", {31'd0, r_walked}, 32'd1);
    lookup({12'h006, 8'd0, 12'h0}, 2'b10, 1'b0);
    chk("R9", "in place hit", {31'd0, r_walked}, 32'd0);
    lookup({12'h006, 8'(NE), 12'h0}, 2'b01, 1'b0);
    lookup({12'h006, 8'd1, 12'h0}, 2'b01, 1'b0);
    chk("R9", "pointer not advanced", {31'd0, r_walked}, 32'd0);
    lookup({12'h006, 8'd0, 12'h0}, 2'b01, 1'b0);
    chk("R9", "in-place slot reused", {31'd0, r_walked}, 32'd1);

    tag = "R12";
    pulse_cr3();
    lookup(32'h0007_0000, 2'b01, 1'b0);
    lookup(32'h0007_1000, 2'b01, 1'b0);
    invalidate(32'h0007_0FFF, 1'b1, 2'd0, 1'b0, gp, ud);
    chk("R12", "clean inv no gp", {31'd0, gp}, 32'd0);
    chk("R12", "clean inv no ud", {31'd0, ud}, 32'd0);
    lookup(32'h0007_1000, 2'b01, 1'b0);
    chk("R12", "other page kept", {31'd0, r_walked}, 32'd0);
    lookup(32'h0007_0000, 2'b01, 1'b0);
    chk("R12", "target dropped", {31'd0, r_walked}, 32'd1);

    tag = "R13";
    invalidate(32'h0007_1000, 1'b1, 2'd3, 1'b0, gp, ud);
    chk("R13", "gp at cpl3", {30'd0, gp, ud}, 32'd2);
    lookup(32'h0007_1000, 2'b01, 1'b0);
    chk("R13", "gp keeps entry", {31'd0, r_walked}, 32'd0);
    invalidate(32'h0007_1000, 1'b0, 2'd3, 1'b1, gp, ud);
    chk("R13", "ud reg form", {30'd0, gp, ud}, 32'd1);
    lookup(32'h0007_1000, 2'b01, 1'b0);
    chk("R13", "ud keeps entry", {31'd0, r_walked}, 32'd0);
    invalidate(32'h0007_1000, 1'b1, 2'd1, 1'b1, gp, ud);
    chk("R13", "gp priority", {30'd0, gp, ud}, 32'd2);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule